// File: doc/BRIEF.md
# Staged Four-Bit Arithmetic and Logic Unit

This block is a small arithmetic and logic unit that a sequencer drives with one 4-bit command per clock. It has four functional units: two adders, a multiplier and a bitwise unit. Each unit keeps its own pair of latched operands. The unit does not take an opcode and its operands in the same cycle. Instead, separate load commands first copy one of two input buses into a unit's operand register. A later run command then fires that unit and captures the outcome in a registered result bus.

Half of the command space loads operands and the other half runs units. Because every unit keeps its own operands, a controller can stage the inputs for several units and then run them back to back. A multiply produces an 8-bit product, so its upper nibble goes to a separate excess output. Add and subtract record a carry or borrow flag. The command input uses a valid/ready handshake. Ready is low while reset is held and stays high from the first clock after reset, so the block applies no back-pressure. Each accepted run command raises a one-cycle result-valid pulse. The result side has no ready input and is never stalled: a consumer that wants a result must take it while the pulse is high or before the next run.

Top module: `staged_alu4`

## Requirements
- R1: While reset is asserted and on the first clock after it, every operand latch, `res_q`, `excess_q`, `carry_q`, `borrow_q` and `res_valid` read as zero, and `cmd_ready` is low.
- R2: A command is accepted when `cmd_valid` and `cmd_ready` are both high at a rising edge. Command codes 0 to 7 are loads. Bits [2:1] of the code select the unit (0 first adder, 1 second adder, 2 multiplier, 3 bitwise unit). Bit 0 clear loads operand A from `bus_a`; bit 0 set loads operand B from `bus_b`.
- R3: Codes 8 and 9 add A and B of the first and second adder respectively. The sum modulo 16 goes to `res_q`, `carry_q` takes the fifth bit of the sum, and `borrow_q` clears.
- R4: Codes 10 and 11 compute A minus B modulo 16 on the first and second adder. `borrow_q` is set when A is less than B, and `carry_q` clears.
- R5: Code 12 multiplies the multiplier operands. Product bits [3:0] go to `res_q`, product bits [7:4] go to `excess_q`, and both flags clear.
- R6: Codes 13, 14 and 15 apply AND, XOR and OR respectively to the bitwise unit operands, place the result on `res_q` and clear both flags.
- R7: Load commands, idle cycles and non-accepted commands leave `res_q`, `carry_q` and `borrow_q` unchanged. `excess_q` changes only on a multiply.
- R8: When `cmd_valid` is low, the command and buses are ignored: no operand latch and no output changes.
- R9: Every output is registered. A run's results appear one cycle after the accepting edge, and `res_valid` is high for exactly that cycle. An operand loaded at one edge is used by a run accepted at the next edge.
- R10: `cmd_ready` rises at the first clock after reset is released and stays high until reset is asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_ready | output | 1 | Block can accept a command |
| cmd | input | 4 | Command code |
| bus_a | input | 4 | First data bus, source of operand A |
| bus_b | input | 4 | Second data bus, source of operand B |
| res_q | output | 4 | Registered result bus |
| excess_q | output | 4 | Upper nibble of the last product |
| carry_q | output | 1 | Carry from the last run, set only by an addition |
| borrow_q | output | 1 | Borrow from the last run, set only by a subtraction |
| res_valid | output | 1 | One-cycle pulse after each accepted run |

## Verification
Every result, flag and the valid pulse is due exactly one clock after the edge that accepts the run. An operand load is due at that same edge, so it is seen by a run accepted on the next edge. The bench drives inputs on the falling edge, lets one rising edge pass, and compares all outputs at the following falling edge against a model that applied the same command. Hold behaviour is checked on each cycle, because every output is compared every cycle whether or not a run happened.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int unsigned CMD_W = 4;
  localparam int unsigned N_UNIT = 4;

  localparam logic [1:0] U_ADD0 = 2'd0;
  localparam logic [1:0] U_ADD1 = 2'd1;
  localparam logic [1:0] U_MUL  = 2'd2;
  localparam logic [1:0] U_BIT  = 2'd3;

  typedef enum logic [CMD_W-1:0] {
    OP_ADD0 = 4'h8,
    OP_ADD1 = 4'h9,
    OP_SUB0 = 4'hA,
    OP_SUB1 = 4'hB,
    OP_MUL  = 4'hC,
    OP_AND  = 4'hD,
    OP_XOR  = 4'hE,
    OP_OR   = 4'hF
  } run_op_e;

  function automatic logic is_run(input logic [CMD_W-1:0] c);
    return c[CMD_W-1];
  endfunction
endpackage

// File: rtl/alu4_opnd_bank.sv
module alu4_opnd_bank #(
  parameter int unsigned W  = 4,
  parameter int unsigned NU = 4,
  localparam int unsigned UW = $clog2(NU)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_en,
  input  logic [UW-1:0]         ld_unit,
  input  logic                  ld_sel_b,
  input  logic [W-1:0]          bus_a,
  input  logic [W-1:0]          bus_b,
  output logic [NU-1:0][W-1:0]  opa_o,
  output logic [NU-1:0][W-1:0]  opb_o
);
  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic hit;
    assign hit = ld_en && (ld_unit == UW'(u));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        opa_o[u] <= '0;
        opb_o[u] <= '0;
      end else if (hit) begin
        if (ld_sel_b) opb_o[u] <= bus_b;
        else          opa_o[u] <= bus_a;
      end
    end
  end
endmodule

// File: rtl/alu4_exec.sv
module alu4_exec
  import alu4_pkg::*;
#(
  parameter int unsigned W  = 4,
  parameter int unsigned NU = 4
) (
  input  logic [CMD_W-1:0]      op,
  input  logic [NU-1:0][W-1:0]  opa,
  input  logic [NU-1:0][W-1:0]  opb,
  output logic [W-1:0]          res,
  output logic [W-1:0]          hi,
  output logic                  cy,
  output logic                  bw
);
  logic [W:0]     sum0, sum1;
  logic [W:0]     dif0, dif1;
  logic [2*W-1:0] prod;

  always_comb begin
    sum0 = {1'b0, opa[U_ADD0]} + {1'b0, opb[U_ADD0]};
    sum1 = {1'b0, opa[U_ADD1]} + {1'b0, opb[U_ADD1]};
    dif0 = {1'b0, opa[U_ADD0]} - {1'b0, opb[U_ADD0]};
    dif1 = {1'b0, opa[U_ADD1]} - {1'b0, opb[U_ADD1]};
    prod = (2*W)'(opa[U_MUL]) * (2*W)'(opb[U_MUL]);
    res  = '0;
    hi   = '0;
    cy   = 1'b0;
    bw   = 1'b0;
    case (op)
      OP_ADD0: begin res = sum0[W-1:0]; cy = sum0[W]; end
      OP_ADD1: begin res = sum1[W-1:0]; cy = sum1[W]; end
      OP_SUB0: begin res = dif0[W-1:0]; bw = dif0[W]; end
      OP_SUB1: begin res = dif1[W-1:0]; bw = dif1[W]; end
      OP_MUL:  begin res = prod[W-1:0]; hi = prod[2*W-1:W]; end
      OP_AND:  res = opa[U_BIT] & opb[U_BIT];
      OP_XOR:  res = opa[U_BIT] ^ opb[U_BIT];
      OP_OR:   res = opa[U_BIT] | opb[U_BIT];
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/staged_alu4.sv
module staged_alu4
  import alu4_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd,
  input  logic [W-1:0]     bus_a,
  input  logic [W-1:0]     bus_b,
  output logic [W-1:0]     res_q,
  output logic [W-1:0]     excess_q,
  output logic             carry_q,
  output logic             borrow_q,
  output logic             res_valid
);
  localparam int unsigned UW = $clog2(N_UNIT);

  logic                     take;
  logic                     take_run;
  logic                     take_ld;
  logic [N_UNIT-1:0][W-1:0] opa, opb;
  logic [W-1:0]             x_res, x_hi;
  logic                     x_cy, x_bw;

  assign take     = cmd_valid && cmd_ready;
  assign take_run = take && is_run(cmd);
  assign take_ld  = take && !is_run(cmd);

  alu4_opnd_bank #(.W(W), .NU(N_UNIT)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (take_ld),
    .ld_unit  (cmd[UW:1]),
    .ld_sel_b (cmd[0]),
    .bus_a    (bus_a),
    .bus_b    (bus_b),
    .opa_o    (opa),
    .opb_o    (opb)
  );

  alu4_exec #(.W(W), .NU(N_UNIT)) u_exec (
    .op  (cmd),
    .opa (opa),
    .opb (opb),
    .res (x_res),
    .hi  (x_hi),
    .cy  (x_cy),
    .bw  (x_bw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_ready <= 1'b0;
    else        cmd_ready <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q     <= '0;
      excess_q  <= '0;
      carry_q   <= 1'b0;
      borrow_q  <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= take_run;
      if (take_run) begin
        res_q    <= x_res;
        carry_q  <= x_cy;
        borrow_q <= x_bw;
        if (cmd == OP_MUL) excess_q <= x_hi;
      end
    end
  end
endmodule

// File: rtl/alu4_chk.sv
module alu4_chk
  import alu4_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [CMD_W-1:0] cmd,
  input logic [W-1:0]     res_q,
  input logic [W-1:0]     excess_q,
  input logic             carry_q,
  input logic             borrow_q,
  input logic             res_valid
);
  // R7: a load leaves result and flags untouched
  p_load_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd[CMD_W-1]) |=>
      ($stable(res_q) && $stable(carry_q) && $stable(borrow_q)));

  // R7: excess only moves after a multiply
  p_excess_mul_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(excess_q) |-> $past(cmd_valid && cmd_ready && cmd == OP_MUL));

  // R8: idle cycle changes nothing
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(res_q) && $stable(excess_q) && !res_valid));

  // R3 / R4: flags never both set
  p_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_q && borrow_q));

  // R9: pulse follows an accepted run
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(cmd_valid && cmd_ready && cmd[CMD_W-1]));

  // R10: ready holds once raised
  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_ready) |-> cmd_ready);
endmodule

bind staged_alu4 alu4_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd       (cmd),
  .res_q     (res_q),
  .excess_q  (excess_q),
  .carry_q   (carry_q),
  .borrow_q  (borrow_q),
  .res_valid (res_valid)
);

// File: tb/tb_staged_alu4.sv
module tb_staged_alu4;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd = '0;
  logic [3:0] bus_a = '0;
  logic [3:0] bus_b = '0;
  logic       cmd_ready;
  logic [3:0] res_q, excess_q;
  logic       carry_q, borrow_q, res_valid;

  int errs = 0;
  int chks = 0;

  logic [3:0] m_a [4];
  logic [3:0] m_b [4];
  logic [3:0] m_res = '0, m_exc = '0;
  logic       m_cy = 1'b0, m_bw = 1'b0, m_rv = 1'b0;
  string      m_tag = "R1";

  always #2 clk = ~clk;

  staged_alu4 dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd(cmd), .bus_a(bus_a), .bus_b(bus_b), .res_q(res_q),
    .excess_q(excess_q), .carry_q(carry_q), .borrow_q(borrow_q),
    .res_valid(res_valid)
  );

  task automatic chk(string tag, string what, int act, int exp);
    chks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all();
    chk(m_tag, "res_q", res_q, m_res);
    chk(m_tag, "excess_q", excess_q, m_exc);
    chk(m_tag, "carry_q", carry_q, m_cy);
    chk(m_tag, "borrow_q", borrow_q, m_bw);
    chk("R9", "res_valid", res_valid, m_rv);
    chk("R10", "cmd_ready", cmd_ready, 1);
  endtask

  // model of one accepted edge
  task automatic model(logic v, logic [3:0] c, logic [3:0] a, logic [3:0] b);
    logic [4:0] s;
    logic [7:0] p;
    int u;
    m_rv = v && c[3];
    if (!v) begin m_tag = "R8"; return; end
    u = c[2:1];
    if (!c[3]) begin
      m_tag = "R7";
      if (c[0]) m_b[u] = b; else m_a[u] = a;
      return;
    end
    m_cy = 0; m_bw = 0;
    case (c)
      4'h8, 4'h9: begin
        u = c[0]; s = {1'b0, m_a[u]} + {1'b0, m_b[u]};
        m_res = s[3:0]; m_cy = s[4]; m_tag = "R3";
      end
      4'hA, 4'hB: begin
        u = c[0]; m_res = m_a[u] - m_b[u]; m_bw = m_a[u] < m_b[u]; m_tag = "R4";
      end
      4'hC: begin
        p = m_a[2] * m_b[2]; m_res = p[3:0]; m_exc = p[7:4]; m_tag = "R5";
      end
      4'hD: begin m_res = m_a[3] & m_b[3]; m_tag = "R6"; end
      4'hE: begin m_res = m_a[3] ^ m_b[3]; m_tag = "R6"; end
      default: begin m_res = m_a[3] | m_b[3]; m_tag = "R6"; end
    endcase
  endtask

  task automatic step(logic v, logic [3:0] c, logic [3:0] a, logic [3:0] b);
    cmd_valid = v; cmd = c; bus_a = a; bus_b = b;
    model(v, c, a, b);
    @(negedge clk);
    chk_all();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  endtask

  initial begin
    #800000;
    errs++; chks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin m_a[i] = '0; m_b[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "res_q", res_q, 0);
    chk("R1", "excess_q", excess_q, 0);
    chk("R1", "res_valid", res_valid, 0);
    chk("R10", "cmd_ready low in reset", cmd_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "cmd_ready after reset", cmd_ready, 1);
    // R1: operands cleared, run gives zero
    step(1, 4'h8, 4'h0, 4'h0);
    chk("R1", "sum of reset operands", res_q, 0);
    // R2 / R3 directed: 15 + 1 wraps with carry
    step(1, 4'h0, 4'hF, 4'h0);
    step(1, 4'h1, 4'h0, 4'h1);
    step(1, 4'h8, 4'h0, 4'h0);
    chk("R3", "wrap sum", res_q, 0);
    chk("R3", "carry", carry_q, 1);
    // R4 directed: 3 - 5 borrows
    step(1, 4'h2, 4'h3, 4'h0);
    step(1, 4'h3, 4'h0, 4'h5);
    step(1, 4'hB, 4'h0, 4'h0);
    chk("R4", "3-5", res_q, 14);
    chk("R4", "borrow", borrow_q, 1);
    // R5 directed: 15 * 15 = 225
    step(1, 4'h4, 4'hF, 4'h0);
    step(1, 4'h5, 4'h0, 4'hF);
    step(1, 4'hC, 4'h0, 4'h0);
    chk("R5", "low nibble", res_q, 1);
    chk("R5", "excess nibble", excess_q, 14);
    // R6 and R7: bitwise run keeps excess
    step(1, 4'h6, 4'hC, 4'h0);
    step(1, 4'h7, 4'h0, 4'hA);
    step(1, 4'hE, 4'h0, 4'h0);
    chk("R6", "xor", res_q, 6);
    chk("R7", "excess held", excess_q, 14);
    // R8: ignored command with valid low
    step(0, 4'hD, 4'h1, 4'h1);
    chk("R8", "ignored", res_q, 6);
    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, 4'($urandom), 4'($urandom), 4'($urandom));
    finish_run();
  end
endmodule